// File: doc/BRIEF.md
# Output Rounding, Saturation and Format Stage

This block turns full-precision signed results from a filter datapath into 16-bit output words. Each input word carries `FRAC_W` fractional bits below the output LSB. The stage rounds the word to a precision that software selects at run time, anywhere from 8 to 16 significant bits, and clears every bit below that precision. It clamps values that do not fit the 16-bit range. As a last step it can flip the sign bit, which turns two's complement into offset binary.

There are two lanes, A and B. They carry independent data and share the round select and the format select. Each lane has an active-low output enable. While the enable is inactive, the lane shows a fixed idle word of zero and drops its valid flag, which stands in for a bus that has been released. Every output is registered, so results appear one clock after their inputs. The control inputs are sampled on the same edge as the data they apply to.

Top module: `hb_out_fmt`

## Requirements
- R1: Data and valid outputs are registered with exactly one clock of latency; `x_valid_o` is `x_valid_i` from the previous edge, provided the lane was enabled on that edge.
- R2: `rnd_sel_i` sets the kept precision: 0→8, 1→10, 2→12, 3→13, 4→14, 5→15, 6→16 bits, and 7 behaves like 6 (16 bits).
- R3: Output bits below the kept precision are zero. With code 0, bits [7:0] are zero.
- R4: Rounding adds half of one kept LSB to the value and then truncates toward minus infinity, so an exact tie rounds upward (for example, +5.5 LSB gives 6 and -5.5 LSB gives -5).
- R5: A rounded result above the largest value that fits in the kept precision becomes 0x7FFF with the cleared low bits. A result below the smallest value becomes 0x8000.
- R6: When `fmt_i` is 1, bit 15 of the saturated result is inverted (offset binary). When `fmt_i` is 0, the result is plain two's complement.
- R7: A lane whose `x_oe_ni` was 1 on the previous edge outputs 0x0000 with valid low, whatever its data and `fmt_i` were.
- R8: While `rst_ni` is low, both lanes output 0x0000 with valid low.
- R9: The lanes share the controls but not the data. Disabling one lane does not change the other lane's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rnd_sel_i | input | 3 | Precision select code |
| fmt_i | input | 1 | 1 = offset binary output |
| a_data_i | input | IN_W | Lane A full-precision signed input |
| a_valid_i | input | 1 | Lane A input valid |
| a_oe_ni | input | 1 | Lane A output enable, active low |
| a_data_o | output | 16 | Lane A output word |
| a_valid_o | output | 1 | Lane A output valid |
| b_data_i | input | IN_W | Lane B full-precision signed input |
| b_valid_i | input | 1 | Lane B input valid |
| b_oe_ni | input | 1 | Lane B output enable, active low |
| b_data_o | output | 16 | Lane B output word |
| b_valid_o | output | 1 | Lane B output valid |

## Verification
The hardest cases to reach are rounding carries that push a value just past the top of the range, since they only saturate after the half-LSB addition. Exact ties on negative values are hard for the same reason, because there the truncation direction decides the result. The stimulus table places inputs one fractional step on each side of these boundaries at several precisions, and pairs each lane with a different boundary so that both paths are exercised on the same edge. Directed steps then disable one lane while the other keeps producing data, and they confirm the one-clock latency by sampling before and after an edge.

// File: rtl/hb_fmt_pkg.sv
package hb_fmt_pkg;
  localparam int OUT_W  = 16;
  localparam int DROP_W = 4;

  typedef struct packed {
    logic [DROP_W-1:0] drop;  // low bits cleared below kept precision
    logic              fmt;   // offset binary
  } fmt_ctrl_t;

  function automatic logic [DROP_W-1:0] sel_to_drop(input logic [2:0] sel);
    unique case (sel)
      3'd0:    return DROP_W'(8);
      3'd1:    return DROP_W'(6);
      3'd2:    return DROP_W'(4);
      3'd3:    return DROP_W'(3);
      3'd4:    return DROP_W'(2);
      3'd5:    return DROP_W'(1);
      default: return DROP_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/hb_fmt_dec.sv
module hb_fmt_dec
  import hb_fmt_pkg::*;
(
  input  logic [2:0] rnd_sel_i,
  input  logic       fmt_i,
  output fmt_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o.drop = sel_to_drop(rnd_sel_i);
    ctrl_o.fmt  = fmt_i;
  end
endmodule

// File: rtl/hb_fmt_round.sv
module hb_fmt_round
  import hb_fmt_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 6,
  localparam int EXT_W = IN_W + 1,
  localparam int SH_W  = $clog2(FRAC_W + OUT_W + 1) + 1
) (
  input  logic [IN_W-1:0]   data_i,
  input  logic [DROP_W-1:0] drop_i,
  output logic [EXT_W-1:0]  q_o     // rounded value in units of kept LSB
);
  logic [SH_W-1:0]         shift;
  logic signed [EXT_W-1:0] ext, half, sum;

  always_comb begin
    shift = SH_W'(FRAC_W) + SH_W'(drop_i);
    ext   = signed'({data_i[IN_W-1], data_i});
    half  = signed'(EXT_W'(1) << (shift - SH_W'(1)));
    sum   = ext + half;
    q_o   = sum >>> shift;
  end
endmodule

// File: rtl/hb_fmt_sat.sv
module hb_fmt_sat
  import hb_fmt_pkg::*;
#(
  parameter int EXT_W = 25
) (
  input  logic [EXT_W-1:0] q_i,
  input  fmt_ctrl_t        ctrl_i,
  output logic [OUT_W-1:0] word_o
);
  localparam int PW_W = $clog2(OUT_W) + 1;

  logic [PW_W-1:0]         pw;
  logic signed [EXT_W-1:0] lim, q_max, q_min, q_s, q_c;
  logic [OUT_W-1:0]        w;

  always_comb begin
    pw    = PW_W'(OUT_W - 1) - PW_W'(ctrl_i.drop);
    lim   = signed'(EXT_W'(1) << pw);
    q_max = lim - EXT_W'(1);
    q_min = -lim;
    q_s   = signed'(q_i);
    if (q_s > q_max)      q_c = q_max;
    else if (q_s < q_min) q_c = q_min;
    else                  q_c = q_s;
    w      = OUT_W'(q_c) << ctrl_i.drop;
    word_o = {w[OUT_W-1] ^ ctrl_i.fmt, w[OUT_W-2:0]};
  end
endmodule

// File: rtl/hb_fmt_lane.sv
module hb_fmt_lane
  import hb_fmt_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_ctrl_t        ctrl_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_i,
  input  logic             oe_ni,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  localparam int EXT_W = IN_W + 1;

  logic [EXT_W-1:0] q;
  logic [OUT_W-1:0] word;

  hb_fmt_round #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_round (
    .data_i (data_i),
    .drop_i (ctrl_i.drop),
    .q_o    (q)
  );

  hb_fmt_sat #(.EXT_W(EXT_W)) u_sat (
    .q_i    (q),
    .ctrl_i (ctrl_i),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (oe_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= word;
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/hb_out_fmt.sv
module hb_out_fmt
  import hb_fmt_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       rnd_sel_i,
  input  logic             fmt_i,
  input  logic [IN_W-1:0]  a_data_i,
  input  logic             a_valid_i,
  input  logic             a_oe_ni,
  output logic [OUT_W-1:0] a_data_o,
  output logic             a_valid_o,
  input  logic [IN_W-1:0]  b_data_i,
  input  logic             b_valid_i,
  input  logic             b_oe_ni,
  output logic [OUT_W-1:0] b_data_o,
  output logic             b_valid_o
);
  localparam int LANES = 2;

  fmt_ctrl_t        ctrl;
  logic [IN_W-1:0]  din   [LANES];
  logic             vin   [LANES];
  logic             oen   [LANES];
  logic [OUT_W-1:0] dout  [LANES];
  logic             vout  [LANES];

  hb_fmt_dec u_dec (
    .rnd_sel_i (rnd_sel_i),
    .fmt_i     (fmt_i),
    .ctrl_o    (ctrl)
  );

  assign din[0] = a_data_i;
  assign vin[0] = a_valid_i;
  assign oen[0] = a_oe_ni;
  assign din[1] = b_data_i;
  assign vin[1] = b_valid_i;
  assign oen[1] = b_oe_ni;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    hb_fmt_lane #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ctrl_i  (ctrl),
      .data_i  (din[l]),
      .valid_i (vin[l]),
      .oe_ni   (oen[l]),
      .data_o  (dout[l]),
      .valid_o (vout[l])
    );
  end

  assign a_data_o  = dout[0];
  assign a_valid_o = vout[0];
  assign b_data_o  = dout[1];
  assign b_valid_o = vout[1];
endmodule

// File: rtl/hb_out_fmt_chk.sv
module hb_out_fmt_chk #(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      rnd_sel_i,
  input logic            fmt_i,
  input logic [IN_W-1:0] a_data_i,
  input logic            a_valid_i,
  input logic            a_oe_ni,
  input logic [15:0]     a_data_o,
  input logic            a_valid_o,
  input logic            b_oe_ni,
  input logic [15:0]     b_data_o,
  input logic            b_valid_o
);
  AST_IDLE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_ni |=> (a_data_o == 16'h0000 && !a_valid_o)); // R7
  AST_IDLE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_ni |=> (b_data_o == 16'h0000 && !b_valid_o)); // R7
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_ni && a_valid_i) |=> a_valid_o); // R1
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_ni && rnd_sel_i == 3'b000) |=> (a_data_o[7:0] == 8'h00)); // R3
  AST_SAT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_ni && !fmt_i && rnd_sel_i == 3'b110 && !a_data_i[IN_W-1] && a_data_i[IN_W-2])
    |=> (a_data_o == 16'h7FFF)); // R5
  AST_FMT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_oe_ni && fmt_i && a_data_i == '0) |=> (a_data_o == 16'h8000)); // R6
endmodule

bind hb_out_fmt hb_out_fmt_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rnd_sel_i (rnd_sel_i),
  .fmt_i     (fmt_i),
  .a_data_i  (a_data_i),
  .a_valid_i (a_valid_i),
  .a_oe_ni   (a_oe_ni),
  .a_data_o  (a_data_o),
  .a_valid_o (a_valid_o),
  .b_oe_ni   (b_oe_ni),
  .b_data_o  (b_data_o),
  .b_valid_o (b_valid_o)
);

// File: tb/hb_out_fmt_test.sv
`timescale 1ns/1ps
module hb_out_fmt_test;
  localparam int IN_W = 24;
  localparam int NV   = 15;

  typedef struct packed {
    logic [2:0]      rnd;
    logic            fmt;
    logic [IN_W-1:0] a_in;
    logic [15:0]     a_exp;
    logic [IN_W-1:0] b_in;
    logic [15:0]     b_exp;
  } vec_t;

  // inputs carry 6 fractional bits below the output LSB
  localparam vec_t VECS [NV] = '{
    '{3'd6, 1'b0, 24'(6400),         16'h0064, 24'(-6400),       16'hFF9C}, // R2 plain
    '{3'd6, 1'b0, 24'(352),          16'h0006, 24'(-352),        16'hFFFB}, // R4 ties
    '{3'd6, 1'b0, 24'(351),          16'h0005, 24'(-353),        16'hFFFA}, // R4 near ties
    '{3'd0, 1'b0, 24'(4660*64),      16'h1200, 24'(4736*64),     16'h1300}, // R2 R3 8 bit
    '{3'd0, 1'b0, 24'(32767*64),     16'h7F00, 24'(-32768*64),   16'h8000}, // R5 carry sat
    '{3'd1, 1'b0, 24'(291*64),       16'h0140, 24'(-291*64),     16'hFEC0}, // R2 10 bit
    '{3'd2, 1'b0, 24'(2748*64),      16'h0AC0, 24'(2743*64),     16'h0AB0}, // R2 12 bit
    '{3'd3, 1'b0, 24'(5*64),         16'h0008, 24'(3*64),        16'h0000}, // R2 13 bit
    '{3'd4, 1'b0, 24'(32766*64),     16'h7FFC, 24'(6*64),        16'h0008}, // R5 14 bit
    '{3'd5, 1'b0, 24'(3*64),         16'h0004, 24'(-3*64),       16'hFFFE}, // R2 15 bit
    '{3'd7, 1'b0, 24'(7*64+32),      16'h0008, 24'(-1),          16'h0000}, // R2 code 7
    '{3'd6, 1'b1, 24'(0),            16'h8000, 24'(-64),         16'h7FFF}, // R6
    '{3'd6, 1'b1, 24'h3FFFFF,        16'hFFFF, 24'hC00000,       16'h0000}, // R5 R6
    '{3'd6, 1'b0, 24'(32767*64+31),  16'h7FFF, 24'(32767*64+32), 16'h7FFF}, // R5 edge
    '{3'd0, 1'b1, 24'(4660*64),      16'h9200, 24'(-64),         16'h8000}  // R6 R3
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      rnd_sel = 3'd6;
  logic            fmt = 1'b0;
  logic [IN_W-1:0] a_din = '0, b_din = '0;
  logic            a_vin = 1'b0, b_vin = 1'b0;
  logic            a_oen = 1'b0, b_oen = 1'b0;
  logic [15:0]     a_dout, b_dout;
  logic            a_vout, b_vout;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  hb_out_fmt #(.IN_W(IN_W), .FRAC_W(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rnd_sel_i(rnd_sel), .fmt_i(fmt),
    .a_data_i(a_din), .a_valid_i(a_vin), .a_oe_ni(a_oen),
    .a_data_o(a_dout), .a_valid_o(a_vout),
    .b_data_i(b_din), .b_valid_i(b_vin), .b_oe_ni(b_oen),
    .b_data_o(b_dout), .b_valid_o(b_vout)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 a_data", a_dout, 16'h0000);
    chk("R8 b_data", b_dout, 16'h0000);
    chk("R8 valids", {14'd0, a_vout, b_vout}, 16'h0000);
    rst_n = 1'b1;
    a_vin = 1'b1;
    b_vin = 1'b1;

    for (int i = 0; i < NV; i++) begin
      rnd_sel = VECS[i].rnd;
      fmt     = VECS[i].fmt;
      a_din   = VECS[i].a_in;
      b_din   = VECS[i].b_in;
      step();
      chk($sformatf("R2-table v%0d lane A", i), a_dout, VECS[i].a_exp);
      chk($sformatf("R9 table v%0d lane B", i), b_dout, VECS[i].b_exp);
    end
    chk("R1 valid both", {14'd0, a_vout, b_vout}, 16'h0003);

    // R1 latency: new input must not show before the edge
    rnd_sel = 3'd6; fmt = 1'b0;
    a_din = 24'(1000*64); b_din = 24'(-1000*64);
    #1;
    chk("R1 hold before edge", a_dout, 16'h9200);
    step();
    chk("R1 after edge A", a_dout, 16'h03E8);
    chk("R1 after edge B", b_dout, 16'hFC18);

    // R1 valid follows valid_i
    a_vin = 1'b0;
    step();
    chk("R1 valid low", {15'd0, a_vout}, 16'h0000);
    chk("R1 valid B kept", {15'd0, b_vout}, 16'h0001);
    a_vin = 1'b1;

    // R7 R9 disable lane A only, with fmt set and large data
    fmt = 1'b1; a_oen = 1'b1; a_din = 24'h3FFFFF; b_din = 24'(0);
    step();
    chk("R7 idle data A", a_dout, 16'h0000);
    chk("R7 idle valid A", {15'd0, a_vout}, 16'h0000);
    chk("R9 lane B live", b_dout, 16'h8000);
    chk("R9 lane B valid", {15'd0, b_vout}, 16'h0001);

    // R7 re-enable A, disable B
    a_oen = 1'b0; b_oen = 1'b1; fmt = 1'b0;
    step();
    chk("R7 A resumes", a_dout, 16'h7FFF);
    chk("R7 idle data B", b_dout, 16'h0000);
    chk("R7 idle valid B", {15'd0, b_vout}, 16'h0000);
    b_oen = 1'b0;

    // R8 asynchronous reset mid-stream
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8 async clear A", a_dout, 16'h0000);
    chk("R8 async clear valid", {14'd0, a_vout, b_vout}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule